// File: doc/BRIEF.md
# Command-Response Buffer Control Register File

This block is the host-visible control page of a command/response buffer interface in front of a security coprocessor. The host reaches it through a simple register bus. Writes carry a right-aligned value to a register address. Reads are byte, halfword or word sized and little-endian: the addressed 32-bit word comes back shifted down by the byte offset. Software first claims a locality. It then moves the engine from idle to ready and rings the start doorbell. It may ring the cancel doorbell while a command is in flight, and it polls the status and start registers until the backend reports completion.

Towards the backend, the block issues a one-cycle start pulse together with the command length. It also issues a one-cycle cancel pulse. The backend answers with a completion strobe that carries an error flag. The block also holds constant identification and buffer-descriptor words, which software uses to find the shared buffer and learn its size. Address bits above the 4 KiB page select the locality that a start write comes from. Only locality 0 can ever be assigned.

Top module: `cmdbuf_ctrl_regs`

## Requirements
- R1: After reset the following hold. The locality-state word (offset 0x00) reads 0x80 when `established` is 1: bit 7 is register-valid, bit 1 is assigned, bits 4:2 hold the active locality, and bit 0 is established-inverse. The status word (0x14) reads 0x2: bit 1 is idle and bit 0 is fatal. The start word (0x1C) reads 0. The grant word (0x04) reads 0: bit 0 is granted and bit 1 is seized.
- R2: The identification word (0x20) reads 0x00025811. Its fields are: bits 3:0 type = 1, bits 7:4 version = 1, bit 8 multi-locality = 0, bit 9 idle bypass = 0, bits 12:11 transfer size = 3, bit 13 FIFO = 0, bit 14 CRB = 1, bits 18:17 selector = 1, and bits 31:24 revision = 0. The command size (0x28) and response size (0x30) both read WINDOW minus DATA_OFS (0xF80 by default). The command address (0x2C) and response address (0x34) both read BASE plus DATA_OFS (0xFED40080 by default).
- R3: A write to the start register (offset 0x01C in any page) is accepted only if three conditions hold: the value is exactly 1, start bit 0 is clear, and the write page (address bits 15:12) equals the active locality. An accepted write sets the start bit and gives exactly one start pulse, one cycle later. Every other start write has no effect.
- R4: A write of exactly 1 to the cancel register (0x18) gives a one-cycle cancel pulse only while the start bit is set. Any other cancel write does nothing.
- R5: A completion strobe while the start bit is set clears the start bit. If `done_err` is also high, it sets the fatal bit, which stays set until reset. A completion while no start is pending changes nothing.
- R6: Writing 1 to the locality control register (0x08) sets assigned and granted and clears seized. Writing 2 clears assigned and granted. The value 8 and every other value are ignored.
- R7: Writing 1 to the control-request register (0x10) clears idle. Writing 2 sets idle. Any other value is ignored.
- R8: Read data appears on `rd_data` the cycle after `rd_en`. It equals the addressed word shifted right by 8 times `rd_addr[1:0]`.
- R9: Bit 0 of the locality-state word reads the inverse of the `established` input.
- R10: On an accepted start, `cmd_len` takes the smaller of `hdr_len` and the buffer size, and holds that value until the next accepted start.
- R11: Writes to the identification, size, address and status words leave their read values unchanged.
- R12: While no locality is assigned, the active locality is treated as 0xFF and the active-locality field reads 0. In this state no start write is accepted, from any page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address; bits above 11 select the locality page |
| wr_data | input | 32 | Right-aligned write value |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address; bits 1:0 give the byte offset |
| rd_data | output | 32 | Read value, one cycle after rd_en |
| established | input | 1 | Established flag from the backend |
| hdr_len | input | 32 | Size field of the current command header |
| start_pulse | output | 1 | One-cycle command start |
| cancel_pulse | output | 1 | One-cycle cancel request |
| cmd_len | output | 32 | Command length handed to the backend |
| done | input | 1 | Completion strobe |
| done_err | input | 1 | Completion carries a nonzero result |

## Verification
The assertions assume that `done` is a single-cycle strobe and that `done_err` is meaningful only while `done` is high. They also assume the backend never signals completion in the same cycle that it sees the start pulse. The stimulus raises `done` for exactly one cycle, always several cycles after the start pulse. It also raises `done` at times when nothing is pending, to exercise the ignore path. Writes and reads are never issued in the same cycle.

// File: rtl/cmdbuf_ctrl_regs.sv
module cmdbuf_ctrl_regs #(
  parameter int          ADDR_W   = 16,
  parameter logic [31:0] BASE     = 32'hFED4_0000,
  parameter logic [31:0] WINDOW   = 32'h0000_1000,
  parameter logic [31:0] DATA_OFS = 32'h0000_0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              established,
  input  logic [31:0]       hdr_len,
  output logic              start_pulse,
  output logic              cancel_pulse,
  output logic [31:0]       cmd_len,
  input  logic              done,
  input  logic              done_err
);
  localparam logic [31:0] BUF_SIZE = WINDOW - DATA_OFS;
  localparam logic [31:0] BUF_ADDR = BASE + DATA_OFS;
  localparam logic [31:0] ID_WORD  = 32'h0002_5811;

  localparam logic [11:0] O_LSTATE = 12'h000;
  localparam logic [11:0] O_LSTS   = 12'h004;
  localparam logic [11:0] O_LCTL   = 12'h008;
  localparam logic [11:0] O_REQ    = 12'h010;
  localparam logic [11:0] O_STS    = 12'h014;
  localparam logic [11:0] O_CANCEL = 12'h018;
  localparam logic [11:0] O_START  = 12'h01C;
  localparam logic [11:0] O_ID     = 12'h020;
  localparam logic [11:0] O_CSIZE  = 12'h028;
  localparam logic [11:0] O_CADDR  = 12'h02C;
  localparam logic [11:0] O_RSIZE  = 12'h030;
  localparam logic [11:0] O_RADDR  = 12'h034;

  logic loc_assigned, granted, idle, fatal, start_bit;

  logic [11:0] wr_off;
  logic [7:0]  wr_page, active_loc;
  logic        start_ok;
  logic [31:0] word, clamped;

  assign wr_off     = wr_addr[11:0];
  assign wr_page    = 8'(wr_addr[ADDR_W-1:12]);
  assign active_loc = loc_assigned ? 8'd0 : 8'hFF;
  assign clamped    = (hdr_len < BUF_SIZE) ? hdr_len : BUF_SIZE;
  assign start_ok   = wr_en && wr_off == O_START && wr_data == 32'd1 &&
                      !start_bit && wr_page == active_loc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loc_assigned <= 1'b0;
      granted      <= 1'b0;
      idle         <= 1'b1;
      fatal        <= 1'b0;
      start_bit    <= 1'b0;
      start_pulse  <= 1'b0;
      cancel_pulse <= 1'b0;
      cmd_len      <= '0;
    end else begin
      start_pulse  <= 1'b0;
      cancel_pulse <= 1'b0;
      if (wr_en && wr_off == O_REQ) begin
        if (wr_data == 32'd1)      idle <= 1'b0;
        else if (wr_data == 32'd2) idle <= 1'b1;
      end
      if (wr_en && wr_off == O_LCTL) begin
        if (wr_data == 32'd1) begin
          loc_assigned <= 1'b1;
          granted      <= 1'b1;
        end else if (wr_data == 32'd2) begin
          loc_assigned <= 1'b0;
          granted      <= 1'b0;
        end
      end
      if (wr_en && wr_off == O_CANCEL && wr_data == 32'd1 && start_bit)
        cancel_pulse <= 1'b1;
      if (start_ok) begin
        start_bit   <= 1'b1;
        start_pulse <= 1'b1;
        cmd_len     <= clamped;
      end else if (done && start_bit) begin
        start_bit <= 1'b0;
        if (done_err) fatal <= 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr[11:2])
      O_LSTATE[11:2]: word = {24'd0, 1'b1, 2'b00, 3'b000, loc_assigned, !established};
      O_LSTS[11:2]:   word = {30'd0, 1'b0, granted};
      O_STS[11:2]:    word = {30'd0, idle, fatal};
      O_START[11:2]:  word = {31'd0, start_bit};
      O_ID[11:2]:     word = ID_WORD;
      O_CSIZE[11:2]:  word = BUF_SIZE;
      O_CADDR[11:2]:  word = BUF_ADDR;
      O_RSIZE[11:2]:  word = BUF_SIZE;
      O_RADDR[11:2]:  word = BUF_ADDR;
      default:        word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= word >> {rd_addr[1:0], 3'b000};
  end
endmodule

// File: rtl/cmdbuf_ctrl_regs_chk.sv
module cmdbuf_ctrl_regs_chk #(
  parameter logic [31:0] LIMIT = 32'h0000_0F80
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_pulse,
  input logic        cancel_pulse,
  input logic        done,
  input logic        done_err,
  input logic        start_bit,
  input logic        fatal,
  input logic        assigned,
  input logic [31:0] cmd_len
);
  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> start_bit && $past(!start_bit));
  assert_busy_rise_pulses_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_bit) |-> start_pulse);
  assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  assert_start_needs_owner_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(assigned));
  assert_cancel_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_pulse |-> $past(start_bit));
  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && start_bit |=> !start_bit);
  assert_done_err_fatal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err && start_bit |=> fatal);
  assert_fatal_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);
  assert_len_clamped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_len <= LIMIT);
endmodule

bind cmdbuf_ctrl_regs cmdbuf_ctrl_regs_chk #(.LIMIT(BUF_SIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .cancel_pulse(cancel_pulse),
  .done(done), .done_err(done_err), .start_bit(start_bit), .fatal(fatal),
  .assigned(loc_assigned), .cmd_len(cmd_len));

// File: tb/cmdbuf_ctrl_regs_tb.sv
module cmdbuf_ctrl_regs_tb;
  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, hdr_len = '0;
  logic        established = 1'b1, done = 1'b0, done_err = 1'b0;
  logic [31:0] rd_data, cmd_len;
  logic        start_pulse, cancel_pulse;

  int   n_chk = 0, n_bad = 0, n_start = 0, n_cancel = 0;
  logic rd_seen = 1'b0;
  bit   ended = 1'b0;
  item_t q[$];

  always #2 clk = ~clk;

  cmdbuf_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .established(established),
    .hdr_len(hdr_len), .start_pulse(start_pulse), .cancel_pulse(cancel_pulse),
    .cmd_len(cmd_len), .done(done), .done_err(done_err));

  always @(posedge clk) begin
    rd_seen <= rd_en;
    if (start_pulse)  n_start++;
    if (cancel_pulse) n_cancel++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    if (rd_seen) begin
      if (q.size() == 0) chk("R8 unexpected read", 32'd1, 32'd0);
      else begin
        it = q.pop_front();
        chk(it.tag, rd_data, it.exp);
      end
    end
  end

  task automatic rd(logic [15:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    q.push_back('{exp, tag});
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic complete(logic err);
    @(negedge clk);
    done = 1'b1; done_err = err;
    @(negedge clk);
    done = 1'b0; done_err = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(16'h0000, 32'h80, "R1 locality state");
    rd(16'h0014, 32'h2, "R1 status idle");
    rd(16'h001C, 32'h0, "R1 start clear");
    rd(16'h0004, 32'h0, "R1 grant clear");
    rd(16'h0020, 32'h0002_5811, "R2 id word");
    rd(16'h0028, 32'h0F80, "R2 cmd size");
    rd(16'h002C, 32'hFED4_0080, "R2 cmd addr");
    rd(16'h0030, 32'h0F80, "R2 rsp size");
    rd(16'h0034, 32'hFED4_0080, "R2 rsp addr");
    rd(16'h0021, 32'h0000_0258, "R8 byte offset 1");
    rd(16'h0022, 32'h0000_0002, "R8 offset 2");
    rd(16'h0023, 32'h0, "R8 offset 3");
    rd(16'h002E, 32'h0000_FED4, "R8 halfword upper");
    established = 1'b0;
    rd(16'h0000, 32'h81, "R9 established low");
    established = 1'b1;
    rd(16'h0000, 32'h80, "R9 established high");
    // r5_ completion with nothing pending
    complete(1'b1);
    rd(16'h0014, 32'h2, "R5 stray completion ignored");
    // r12_ no locality
    wr(16'h001C, 32'd1);
    chk("R12 start without locality", n_start, 0);
    rd(16'h001C, 32'h0, "R12 start bit stays clear");
    wr(16'h0008, 32'd1);
    rd(16'h0000, 32'h82, "R6 assigned");
    rd(16'h0004, 32'h1, "R6 granted, seized clear");
    wr(16'h0008, 32'd3);
    wr(16'h0008, 32'd8);
    rd(16'h0000, 32'h82, "R6 odd values ignored");
    wr(16'h101C, 32'd1);
    chk("R3 wrong page rejected", n_start, 0);
    wr(16'h001C, 32'd3);
    chk("R3 wrong value rejected", n_start, 0);
    hdr_len = 32'h20;
    wr(16'h001C, 32'd1);
    chk("R3 accepted start pulses once", n_start, 1);
    rd(16'h001C, 32'h1, "R3 start bit set");
    chk("R10 short length", cmd_len, 32'h20);
    wr(16'h001C, 32'd1);
    chk("R3 start while busy rejected", n_start, 1);
    wr(16'h0018, 32'd2);
    chk("R4 cancel wrong value", n_cancel, 0);
    wr(16'h0018, 32'd1);
    chk("R4 cancel while busy", n_cancel, 1);
    complete(1'b0);
    rd(16'h001C, 32'h0, "R5 completion clears start");
    rd(16'h0014, 32'h2, "R5 clean completion no fatal");
    wr(16'h0018, 32'd1);
    chk("R4 cancel when idle ignored", n_cancel, 1);
    hdr_len = 32'h5000;
    wr(16'h001C, 32'd1);
    chk("R3 second start", n_start, 2);
    chk("R10 length clamped", cmd_len, 32'h0F80);
    hdr_len = 32'h10;
    repeat (2) @(negedge clk);
    chk("R10 length held", cmd_len, 32'h0F80);
    complete(1'b1);
    rd(16'h0014, 32'h3, "R5 error sets fatal");
    rd(16'h001C, 32'h0, "R5 start cleared");
    wr(16'h0010, 32'd1);
    rd(16'h0014, 32'h1, "R7 command ready");
    wr(16'h0010, 32'd3);
    rd(16'h0014, 32'h1, "R7 other value ignored");
    wr(16'h0010, 32'd2);
    rd(16'h0014, 32'h3, "R7 go idle, R5 fatal sticky");
    wr(16'h0020, 32'h0);
    rd(16'h0020, 32'h0002_5811, "R11 id read-only");
    wr(16'h0028, 32'h1);
    rd(16'h0028, 32'h0F80, "R11 size read-only");
    wr(16'h0014, 32'h0);
    rd(16'h0014, 32'h3, "R11 status read-only");
    wr(16'h0008, 32'd2);
    rd(16'h0000, 32'h80, "R6 relinquish");
    rd(16'h0004, 32'h0, "R6 grant cleared");
    wr(16'h001C, 32'd1);
    chk("R12 start after relinquish", n_start, 2);
    repeat (3) @(negedge clk);
    chk("R8 all reads returned", q.size(), 0);
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end
endmodule